// File: doc/BRIEF.md
# Bus Mastership Claim Unit with Daisy-Chained Grant

This block sits between an on-chip DMA engine and a shared system bus on which several masters take turns. When the engine wants the bus, the block pulls the shared active-low bus-request line. It then waits for the arbiter's active-low grant to arrive on its grant input. It also waits for the current master to leave the bus. Only then does it claim ownership by driving the shared active-low grant-acknowledge line. The engine learns it may transfer through the `granted` output. It hands the bus back by pulsing `xfer_done`.

Several such devices can be chained. A device that has no request of its own forwards the incoming grant on its grant-out pin to the next device down the chain. Once a grant has been forwarded, the device keeps forwarding it until the arbiter withdraws it. A request that arrives in the meantime has to wait for a fresh grant. The shared lines are open-drain. For each driven line the block therefore presents an output-enable (`1` = pull the line low) and reads the resolved pin level back as an input. All pin inputs pass through a `SYNC_STAGES`-deep synchronizer before the state machine sees them. Control pins are plain level signals; there is no data stream at this block's edge.

Top module: `busmaster_arb`

## Requirements
- R1: While and after reset, `br_oe` and `bgack_oe` are 0, `bg_out_n` is 1 and `granted` is 0.
- R2: When `need_bus` is 1 in the idle state, `br_oe` becomes 1 and stays 1 while the block waits for the bus.
- R3: With `need_bus` 0 and the block idle, a low `bg_in_n` is forwarded as a low `bg_out_n`, and `bg_out_n` returns high once `bg_in_n` goes high.
- R4: While the block is requesting or owns the bus and has not already forwarded the current grant, `bg_out_n` stays 1.
- R5: The block claims the bus (`bgack_oe` 1, `granted` 1) only when the synchronized `bg_in_n` is low, `bgack_n_in` is high and `dtack_n_in` is high. While either acknowledge line is low, it keeps waiting.
- R6: On the first cycle of ownership both `br_oe` and `bgack_oe` are 1. From the next cycle `br_oe` is 0 while `bgack_oe` stays 1.
- R7: A `xfer_done` pulse during ownership makes `bgack_oe` and `granted` 0 on the following cycle. One cycle later the block is idle.
- R8: A request that arrives after the current grant has been forwarded does not take that grant. `bg_out_n` stays low until `bg_in_n` rises, and the block claims the bus only after `bg_in_n` falls again.
- R9: If `need_bus` drops before ownership, `br_oe` returns to 0 and no claim is made.
- R10: If the grant is withdrawn while the block waits for the bus to become free, no claim is made until a grant is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need_bus | input | 1 | Engine wants mastership (level, held until done) |
| xfer_done | input | 1 | Engine finished; one-cycle pulse while `granted` |
| granted | output | 1 | Engine may use the bus |
| br_oe | output | 1 | Pull shared bus-request line low |
| bg_in_n | input | 1 | Incoming grant, active low |
| bg_out_n | output | 1 | Grant forwarded to next device, active low |
| bgack_n_in | input | 1 | Resolved level of the shared grant-acknowledge line |
| bgack_oe | output | 1 | Pull shared grant-acknowledge line low |
| dtack_n_in | input | 1 | Resolved level of the transfer-acknowledge line |

## Verification
The assertions assume that `xfer_done` is pulsed only while `granted` is 1. They also assume that the grant-acknowledge pin reads low whenever the block itself drives it, as a wired-AND bus does. They further assume that `need_bus` stays high from request until the transfer is done, except when a request is cancelled on purpose. The bench meets these assumptions with a wired model of each shared line. It raises `xfer_done` only after it has seen `granted`. Every pin change is held for well over `SYNC_STAGES` plus one cycles, so the synchronized view has settled before each sample.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_WAIT    = 3'd2,
    ST_OWN     = 3'd3,
    ST_RELEASE = 3'd4
  } arb_state_e;
endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/busarb_chain.sv
module busarb_chain (
  input  logic clk,
  input  logic rst_n,
  input  logic s_grant,
  input  logic idle_free,
  output logic passing,
  output logic bg_out_n
);
  // Once a grant is forwarded it stays forwarded until withdrawn upstream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) passing <= 1'b0;
    else passing <= s_grant & (passing | idle_free);
  end

  assign bg_out_n = ~passing;
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       need_bus,
  input  logic       xfer_done,
  input  logic       s_grant,
  input  logic       s_bgack_busy,
  input  logic       s_dtack_busy,
  input  logic       passing,
  output arb_state_e state,
  output logic       br_oe,
  output logic       bgack_oe,
  output logic       granted
);
  arb_state_e nxt;
  logic       own_first;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (need_bus) nxt = ST_REQUEST;
      ST_REQUEST: begin
        if (!need_bus) nxt = ST_IDLE;
        else if (s_grant && !passing) nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (!need_bus) nxt = ST_IDLE;
        else if (!s_grant) nxt = ST_REQUEST;
        else if (!s_bgack_busy && !s_dtack_busy) nxt = ST_OWN;
      end
      ST_OWN:     if (xfer_done) nxt = ST_RELEASE;
      ST_RELEASE: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      own_first <= 1'b0;
    end else begin
      state     <= nxt;
      own_first <= (nxt == ST_OWN) && (state != ST_OWN);
    end
  end

  assign br_oe    = (state == ST_REQUEST) || (state == ST_WAIT) ||
                    ((state == ST_OWN) && own_first);
  assign bgack_oe = (state == ST_OWN);
  assign granted  = (state == ST_OWN);
endmodule

// File: rtl/busmaster_arb.sv
module busmaster_arb
  import busarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_bus,
  input  logic xfer_done,
  output logic granted,
  output logic br_oe,
  input  logic bg_in_n,
  output logic bg_out_n,
  input  logic bgack_n_in,
  output logic bgack_oe,
  input  logic dtack_n_in
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pins_n, pins_sync_n;
  logic s_grant, s_bgack_busy, s_dtack_busy;
  logic passing, idle_free;
  arb_state_e state;

  assign pins_n = {dtack_n_in, bgack_n_in, bg_in_n};

  busarb_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(pins_sync_n)
  );

  assign s_grant      = ~pins_sync_n[0];
  assign s_bgack_busy = ~pins_sync_n[1];
  assign s_dtack_busy = ~pins_sync_n[2];

  assign idle_free = (state == ST_IDLE) && !need_bus;

  busarb_chain u_chain (
    .clk(clk), .rst_n(rst_n), .s_grant(s_grant), .idle_free(idle_free),
    .passing(passing), .bg_out_n(bg_out_n)
  );

  busarb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .need_bus(need_bus), .xfer_done(xfer_done),
    .s_grant(s_grant), .s_bgack_busy(s_bgack_busy), .s_dtack_busy(s_dtack_busy),
    .passing(passing), .state(state), .br_oe(br_oe), .bgack_oe(bgack_oe),
    .granted(granted)
  );
endmodule

// File: rtl/busarb_checker.sv
module busarb_checker (
  input logic clk,
  input logic rst_n,
  input logic granted,
  input logic br_oe,
  input logic bgack_oe,
  input logic bg_out_n,
  input logic xfer_done,
  input logic s_grant,
  input logic s_bgack_busy,
  input logic s_dtack_busy
);
  // R4: a claimed bus is never forwarded down the chain
  p_no_forward_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bgack_oe |-> bg_out_n);

  // R5 / R10: ownership starts only from a visible grant on an idle bus
  p_claim_needs_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(s_grant && !s_bgack_busy && !s_dtack_busy));

  // R6: request still held on the first owned cycle
  p_br_held_on_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgack_oe) |-> br_oe);

  // R6: request dropped one cycle after the claim
  p_br_dropped_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgack_oe) |=> !br_oe);

  // R6: engine is told of ownership only while acknowledge is driven
  p_grant_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> bgack_oe);

  // R7: done releases the acknowledge on the next cycle
  p_release_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && xfer_done) |=> (!bgack_oe && !granted));
endmodule

bind busmaster_arb busarb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .granted(granted), .br_oe(br_oe),
  .bgack_oe(bgack_oe), .bg_out_n(bg_out_n), .xfer_done(xfer_done),
  .s_grant(s_grant), .s_bgack_busy(s_bgack_busy), .s_dtack_busy(s_dtack_busy)
);

// File: tb/sim_busmaster_arb.sv
module sim_busmaster_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic need_bus = 1'b0, xfer_done = 1'b0;
  logic bg_in_n = 1'b1;
  logic other_bgack = 1'b0, other_dtack = 1'b0;
  logic granted, br_oe, bg_out_n, bgack_oe;
  logic bgack_pin_n, dtack_pin_n;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  assign bgack_pin_n = ~(bgack_oe | other_bgack);
  assign dtack_pin_n = ~other_dtack;

  busmaster_arb u0 (
    .clk(clk), .rst_n(rst_n), .need_bus(need_bus), .xfer_done(xfer_done),
    .granted(granted), .br_oe(br_oe), .bg_in_n(bg_in_n), .bg_out_n(bg_out_n),
    .bgack_n_in(bgack_pin_n), .bgack_oe(bgack_oe), .dtack_n_in(dtack_pin_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_granted(input int max, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (granted) begin ok = 1'b1; break; end
    end
  endtask

  task automatic release_bus(input string req);
    xfer_done = 1'b1; need_bus = 1'b0; bg_in_n = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(req, bgack_oe, 1'b0);
    chk(req, granted, 1'b0);
    cyc(1);
    chk(req, br_oe, 1'b0);
    cyc(6);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 br", br_oe, 1'b0);
    chk("R1 bgack", bgack_oe, 1'b0);
    chk("R1 bgout", bg_out_n, 1'b1);
    chk("R1 granted", granted, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after", br_oe | bgack_oe | granted | ~bg_out_n, 1'b0);
  endtask

  task automatic t_forward();
    bg_in_n = 1'b0; cyc(6);
    chk("R3 forward low", bg_out_n, 1'b0);
    bg_in_n = 1'b1; cyc(6);
    chk("R3 forward high", bg_out_n, 1'b1);
  endtask

  task automatic t_basic_claim();
    bit ok;
    need_bus = 1'b1; cyc(2);
    chk("R2 request", br_oe, 1'b1);
    cyc(6);
    chk("R2 request held", br_oe, 1'b1);
    bg_in_n = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i < 3) chk("R4 no forward while requesting", bg_out_n, 1'b1);
      if (bgack_oe) begin ok = 1'b1; break; end
    end
    chk("R5 claimed", ok, 1'b1);
    chk("R6 br on first owned cycle", br_oe, 1'b1);
    cyc(1);
    chk("R6 br dropped", br_oe, 1'b0);
    chk("R6 bgack held", bgack_oe, 1'b1);
    chk("R4 no forward while owning", bg_out_n, 1'b1);
    release_bus("R7 release");
  endtask

  task automatic t_wait_free();
    bit ok;
    other_bgack = 1'b1; other_dtack = 1'b1;
    need_bus = 1'b1; bg_in_n = 1'b0; cyc(10);
    chk("R5 wait bgack busy", granted, 1'b0);
    chk("R5 still requesting", br_oe, 1'b1);
    other_bgack = 1'b0; cyc(10);
    chk("R5 wait dtack busy", granted, 1'b0);
    other_dtack = 1'b0;
    wait_granted(10, ok);
    chk("R5 claim when free", ok, 1'b1);
    release_bus("R7 release after wait");
  endtask

  task automatic t_grant_withdrawn();
    bit ok;
    other_bgack = 1'b1;
    need_bus = 1'b1; bg_in_n = 1'b0; cyc(10);
    bg_in_n = 1'b1; cyc(6);
    other_bgack = 1'b0; cyc(10);
    chk("R10 no claim without grant", granted, 1'b0);
    chk("R10 request kept", br_oe, 1'b1);
    bg_in_n = 1'b0;
    wait_granted(10, ok);
    chk("R10 claim on new grant", ok, 1'b1);
    release_bus("R7 release after R10");
  endtask

  task automatic t_late_request();
    bit ok;
    bg_in_n = 1'b0; cyc(6);
    chk("R8 forwarded", bg_out_n, 1'b0);
    need_bus = 1'b1; cyc(10);
    chk("R8 keeps forwarding", bg_out_n, 1'b0);
    chk("R8 no claim on old grant", granted, 1'b0);
    chk("R8 request raised", br_oe, 1'b1);
    bg_in_n = 1'b1; cyc(6);
    chk("R8 forward ends", bg_out_n, 1'b1);
    bg_in_n = 1'b0;
    wait_granted(10, ok);
    chk("R8 claim on fresh grant", ok, 1'b1);
    release_bus("R7 release after R8");
  endtask

  task automatic t_cancel();
    need_bus = 1'b1; cyc(4);
    chk("R9 requesting", br_oe, 1'b1);
    need_bus = 1'b0; cyc(3);
    chk("R9 request dropped", br_oe, 1'b0);
    bg_in_n = 1'b0; cyc(8);
    chk("R9 no claim", bgack_oe, 1'b0);
    chk("R9 grant forwarded instead", bg_out_n, 1'b0);
    bg_in_n = 1'b1; cyc(6);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_forward();
        t_basic_claim();
        t_wait_free();
        t_grant_withdrawn();
        t_late_request();
        t_cancel();
        done_flag = 1'b1;
      end
      begin
        for (int i = 0; i < 20000; i++) begin
          @(posedge clk);
          if (done_flag) break;
        end
        if (!done_flag) begin
          checks++; fails++;
          $display("FAIL watchdog actual=hung expected=finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule